// File: doc/BRIEF.md
# DAC Self-Calibration Sequencer

This block is the digital controller behind a self-trimming segmented DAC. A low pulse on the start pin launches a calibration run. The run first trims the zero point: midscale when the output is strapped bipolar, code zero when it is unipolar. It then visits each of the 63 carry transitions between the 64 upper-six-bit segments. For each transition it takes two readings. First it sets the main DAC one code below the segment boundary with the extra LSB on, and nulls the comparator with the transfer DAC. Then it sets the main DAC exactly on the boundary with the extra LSB off, and nulls the comparator with the calibration DAC. The calibration DAC result is stored as that segment's correction word. Every null is a successive-approximation search, one comparator sample per bit, MSB first.

Outside calibration, codes arrive on a valid/ready stream. An accepted code goes to the main DAC output register. Its upper six bits select a stored correction word, which drives the calibration DAC output. While a run is in progress `in_ready` is low, and a source with a pending code must hold `in_code` until `in_ready` returns. The analog converters and the comparator sit outside the block. Here they appear only as code outputs and a single comparator input bit.

Top module: `dcal_seq`

## Requirements
- R1: After reset, `mux_low`, `cal_ok` and `extra_lsb` are 0, `in_ready` is 1, and `main_code` and `cal_code` are 0 (all correction words reset to zero).
- R2: A low level on `cal_start_n` that was high at the previous clock edge starts a run at that edge. From the next cycle, `mux_low` is 1, `in_ready` is 0 and `cal_ok` is 0.
- R3: The first 8 cycles of a run trim the zero point. `main_code` is 0x8000 when `bipolar_sel`=1 and 0 when it is 0, and `extra_lsb`=0. The result of the `cal_code` search is stored as correction word 0.
- R4: For transition k (1 to 63), the next 8 cycles drive `main_code` = k*1024-1 with `extra_lsb`=1 while `xfer_code` is searched.
- R5: The 8 cycles after that drive `main_code` = k*1024 with `extra_lsb`=0 while `cal_code` is searched. The result is stored as correction word k.
- R6: Every search is 8 cycles long. The trial value starts at 0x80, one bit is decided per cycle from MSB to LSB, and `cmp_hi`=1 clears the bit under test. A run therefore lasts 1016 cycles, after which `mux_low` drops and `in_ready` rises.
- R7: `cal_ok` goes to 1 at the end of a run only if no search in that run ended at 0x00 or 0xFF. Otherwise it stays 0.
- R8: A start pulse during a run restarts it from the zero step, with `cal_ok` low and the full 1016-cycle length counted from the new pulse.
- R9: When idle, a code taken with `in_valid`&&`in_ready` appears on `main_code` one cycle later. `cal_code` shows the correction word selected by `main_code[15:10]`. Codes offered while `in_ready`=0 are not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cal_start_n | input | 1 | Active-low start pulse for a calibration run |
| bipolar_sel | input | 1 | Output strapping: 1 bipolar, 0 unipolar |
| cmp_hi | input | 1 | Comparator: 1 when the adjusted output is above the reference |
| in_valid | input | 1 | Stream code valid |
| in_ready | output | 1 | Stream code ready (low during a run) |
| in_code | input | 16 | Stream code |
| main_code | output | 16 | Main DAC code |
| extra_lsb | output | 1 | Extra LSB enable of the main DAC |
| xfer_code | output | 8 | Transfer DAC code |
| cal_code | output | 8 | Calibration DAC code |
| mux_low | output | 1 | Output multiplexer held at bottom of range |
| cal_ok | output | 1 | Last run completed with every search in range |

## Verification
The checks assume that `cmp_hi` has settled within the same cycle as the codes being compared, and that a start pulse is a clean synchronous low level lasting at least one clock. The stimulus satisfies this. The comparator model is a pure combinational function of `main_code`, `extra_lsb`, `xfer_code` and `cal_code`. Its targets are computed arithmetically per segment, and start pulses last exactly one cycle, driven on the falling clock edge. Stream codes are offered for single cycles, or held only while `in_ready` is low. This keeps the acceptance property free of overlap with a start edge.

// File: rtl/dcal_pkg.sv
package dcal_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ZERO = 2'd1,
    ST_XFER = 2'd2,
    ST_CAL  = 2'd3
  } seq_st_e;
endpackage

// File: rtl/dcal_sar.sv
// Successive-approximation search engine, one comparator sample per bit.
module dcal_sar #(
  parameter int TRIM_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              run,
  input  logic              cmp_hi,
  output logic [TRIM_W-1:0] trial,
  output logic              done,
  output logic [TRIM_W-1:0] result
);
  localparam logic [TRIM_W-1:0] TOP_BIT = TRIM_W'(1) << (TRIM_W - 1);

  logic [TRIM_W-1:0] mask;

  // bit under test is dropped when the comparator says the output is high
  assign result = cmp_hi ? (trial & ~mask) : trial;
  assign done   = run && mask[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trial <= '0;
      mask  <= '0;
    end else if (load) begin
      trial <= TOP_BIT;
      mask  <= TOP_BIT;
    end else if (run && !mask[0] && (mask != '0)) begin
      trial <= result | (mask >> 1);
      mask  <= mask >> 1;
    end
  end
endmodule

// File: rtl/dcal_trim_ram.sv
// Correction word storage, one word per upper-code segment.
module dcal_trim_ram #(
  parameter int SEG_W  = 6,
  parameter int TRIM_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEG_W-1:0]  wr_addr,
  input  logic [TRIM_W-1:0] wr_data,
  input  logic [SEG_W-1:0]  rd_addr,
  output logic [TRIM_W-1:0] rd_data
);
  localparam int ENTRIES = 1 << SEG_W;

  logic [TRIM_W-1:0] words [ENTRIES];

  for (genvar gi = 0; gi < ENTRIES; gi++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        words[gi] <= '0;
      else if (wr_en && (wr_addr == SEG_W'(gi)))
        words[gi] <= wr_data;
    end
  end

  assign rd_data = words[rd_addr];
endmodule

// File: rtl/dcal_seq.sv
module dcal_seq
  import dcal_pkg::*;
#(
  parameter int CODE_W = 16,
  parameter int SEG_W  = 6,
  parameter int TRIM_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cal_start_n,
  input  logic              bipolar_sel,
  input  logic              cmp_hi,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [CODE_W-1:0] in_code,
  output logic [CODE_W-1:0] main_code,
  output logic              extra_lsb,
  output logic [TRIM_W-1:0] xfer_code,
  output logic [TRIM_W-1:0] cal_code,
  output logic              mux_low,
  output logic              cal_ok
);
  localparam int                SHIFT   = CODE_W - SEG_W;
  localparam logic [SEG_W-1:0]  LAST_K  = {SEG_W{1'b1}};
  localparam logic [CODE_W-1:0] MID_PT  = CODE_W'(1) << (CODE_W - 1);

  seq_st_e           state;
  logic [SEG_W-1:0]  seg_k;
  logic              start_q;
  logic              fault;
  logic [CODE_W-1:0] norm_main;
  logic [TRIM_W-1:0] xfer_hold;

  logic              start_req;
  logic              busy;
  logic              sar_load;
  logic              sar_done;
  logic [TRIM_W-1:0] sar_trial;
  logic [TRIM_W-1:0] sar_res;
  logic              res_oor;
  logic              last_done;
  logic              ram_we;
  logic [SEG_W-1:0]  ram_waddr;
  logic [TRIM_W-1:0] ram_rd;
  logic [CODE_W-1:0] seg_base;
  logic [CODE_W-1:0] seq_main;

  assign start_req = start_q && !cal_start_n;
  assign busy      = (state != ST_IDLE);
  assign res_oor   = (sar_res == '0) || (sar_res == '1);
  assign last_done = sar_done && (state == ST_CAL) && (seg_k == LAST_K);
  assign sar_load  = start_req || (sar_done && !last_done);
  assign ram_we    = sar_done && !start_req && ((state == ST_ZERO) || (state == ST_CAL));
  assign ram_waddr = (state == ST_ZERO) ? '0 : seg_k;
  assign seg_base  = {seg_k, {SHIFT{1'b0}}};

  always_comb begin
    unique case (state)
      ST_ZERO: seq_main = bipolar_sel ? MID_PT : '0;
      ST_XFER: seq_main = seg_base - CODE_W'(1);
      ST_CAL:  seq_main = seg_base;
      default: seq_main = norm_main;
    endcase
  end

  dcal_sar #(.TRIM_W(TRIM_W)) u_sar (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (sar_load),
    .run    (busy),
    .cmp_hi (cmp_hi),
    .trial  (sar_trial),
    .done   (sar_done),
    .result (sar_res)
  );

  dcal_trim_ram #(.SEG_W(SEG_W), .TRIM_W(TRIM_W)) u_ram (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (ram_we),
    .wr_addr (ram_waddr),
    .wr_data (sar_res),
    .rd_addr (norm_main[CODE_W-1 -: SEG_W]),
    .rd_data (ram_rd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      seg_k     <= '0;
      start_q   <= 1'b1;
      fault     <= 1'b0;
      cal_ok    <= 1'b0;
      norm_main <= '0;
      xfer_hold <= '0;
    end else begin
      start_q <= cal_start_n;
      if (start_req) begin
        state  <= ST_ZERO;
        seg_k  <= SEG_W'(1);
        fault  <= 1'b0;
        cal_ok <= 1'b0;
      end else begin
        unique case (state)
          ST_IDLE: begin
            if (in_valid) norm_main <= in_code;
          end
          ST_ZERO: begin
            if (sar_done) begin
              fault <= fault | res_oor;
              state <= ST_XFER;
            end
          end
          ST_XFER: begin
            if (sar_done) begin
              xfer_hold <= sar_res;
              fault     <= fault | res_oor;
              state     <= ST_CAL;
            end
          end
          ST_CAL: begin
            if (sar_done) begin
              if (seg_k == LAST_K) begin
                state  <= ST_IDLE;
                cal_ok <= !(fault | res_oor);
              end else begin
                fault <= fault | res_oor;
                seg_k <= seg_k + SEG_W'(1);
                state <= ST_XFER;
              end
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  assign in_ready  = !busy;
  assign mux_low   = busy;
  assign extra_lsb = (state == ST_XFER);
  assign main_code = seq_main;
  assign xfer_code = (state == ST_XFER) ? sar_trial : xfer_hold;
  assign cal_code  = ((state == ST_ZERO) || (state == ST_CAL)) ? sar_trial : ram_rd;
endmodule

// File: rtl/dcal_seq_chk.sv
module dcal_seq_chk #(
  parameter int CODE_W = 16,
  parameter int SEG_W  = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cal_start_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [CODE_W-1:0] in_code,
  input logic [CODE_W-1:0] main_code,
  input logic              extra_lsb,
  input logic              mux_low,
  input logic              cal_ok
);
  localparam int SHIFT = CODE_W - SEG_W;

  AST_START_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
    (!cal_start_n && $past(cal_start_n)) |=> (mux_low && !cal_ok && !in_ready)); // R2

  AST_OK_LOW_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    mux_low |-> !cal_ok); // R7

  AST_NO_TAKE_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    mux_low |-> !in_ready); // R9

  AST_XFER_BELOW_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    extra_lsb |-> ((&main_code[SHIFT-1:0]) && mux_low)); // R4

  AST_CODE_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && cal_start_n) |=> (main_code == $past(in_code))); // R9

  AST_RUN_ENDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mux_low) |-> (in_ready && !extra_lsb)); // R6
endmodule

bind dcal_seq dcal_seq_chk #(.CODE_W(CODE_W), .SEG_W(SEG_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cal_start_n (cal_start_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .in_code     (in_code),
  .main_code   (main_code),
  .extra_lsb   (extra_lsb),
  .mux_low     (mux_low),
  .cal_ok      (cal_ok)
);

// File: tb/test_dcal_seq.sv
module test_dcal_seq;
  localparam int RUN_LEN = 8 + 63 * 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cal_start_n = 1'b1;
  logic        bipolar_sel = 1'b0;
  logic        cmp_hi;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_code = '0;
  logic [15:0] main_code;
  logic        extra_lsb;
  logic [7:0]  xfer_code;
  logic [7:0]  cal_code;
  logic        mux_low;
  logic        cal_ok;

  int total = 0;
  int bad = 0;
  int bad_k = -1;
  int bad_val = 0;

  always #10 clk = ~clk;

  dcal_seq i_dcal_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .cal_start_n (cal_start_n),
    .bipolar_sel (bipolar_sel),
    .cmp_hi      (cmp_hi),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .in_code     (in_code),
    .main_code   (main_code),
    .extra_lsb   (extra_lsb),
    .xfer_code   (xfer_code),
    .cal_code    (cal_code),
    .mux_low     (mux_low),
    .cal_ok      (cal_ok)
  );

  // comparator model: per-segment null targets computed arithmetically
  always_comb begin
    int seg, tx, tc;
    seg = int'(main_code >> 10);
    tx  = 10 + ((seg + 1) * 53) % 230;
    tc  = (seg == bad_k) ? bad_val : 20 + (seg * 37) % 200;
    cmp_hi = extra_lsb ? (int'(xfer_code) > tx) : (int'(cal_code) > tc);
  end

  function automatic int exp_entry(int s);
    if (s == bad_k) return (bad_val < 0) ? 0 : ((bad_val > 255) ? 255 : bad_val);
    return 20 + (s * 37) % 200;
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) cal_start_n = 1'b0;
    @(negedge clk) cal_start_n = 1'b1;
  endtask

  task automatic run_cal(bit bip, int restart_at, bit expect_ok, bit with_bp);
    int errs;
    int zero_pt;
    errs = 0;
    zero_pt = bip ? 32768 : 0;
    bipolar_sel = bip;
    pulse_start();
    if (restart_at > 0) begin
      repeat (restart_at) @(negedge clk);
      pulse_start();
      chk(mux_low && !cal_ok && (main_code == 16'(zero_pt)), "R8", "restart state",
          int'(main_code), zero_pt);
    end
    for (int t = 0; t < RUN_LEN; t++) begin
      int exp_main;
      bit exp_x;
      if (t > 0) @(negedge clk);
      if (t < 8) begin
        exp_main = zero_pt;
        exp_x = 1'b0;
      end else begin
        int u, k;
        u = t - 8;
        k = u / 16 + 1;
        exp_x = (u % 16) < 8;
        exp_main = exp_x ? k * 1024 - 1 : k * 1024;
      end
      if (int'(main_code) != exp_main || extra_lsb != exp_x || !mux_low || in_ready || cal_ok)
        errs++;
      if (with_bp) begin
        in_valid = (t >= 100) && (t < 110);
        in_code  = 16'hBEEF;
      end
    end
    in_valid = 1'b0;
    chk(errs == 0, "R3 R4 R5", "sequence cycles wrong", errs, 0);
    @(negedge clk);
    chk(!mux_low && in_ready, "R6", "run end after 1016 cycles", int'(mux_low), 0);
    chk(cal_ok == expect_ok, "R7", "cal_ok", int'(cal_ok), int'(expect_ok));
  endtask

  task automatic sweep(bit bip);
    for (int s = 0; s < 64; s++) begin
      int code, ex;
      code = s * 1024 + (s * 97 + 3) % 1024;
      @(negedge clk);
      in_valid = 1'b1;
      in_code  = 16'(code);
      @(negedge clk);
      in_valid = 1'b0;
      chk(int'(main_code) == code, "R9", "code taken", int'(main_code), code);
      ex = (s == 0) ? exp_entry(bip ? 32 : 0) : exp_entry(s);
      chk(int'(cal_code) == ex, (s == 0) ? "R3" : "R5", "correction word", int'(cal_code), ex);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!mux_low && !cal_ok && !extra_lsb && in_ready, "R1", "control outputs", int'(mux_low), 0);
    chk(main_code == 16'd0 && cal_code == 8'd0, "R1", "codes", int'(main_code), 0);

    // R9 accept before the first run
    @(negedge clk);
    in_valid = 1'b1;
    in_code  = 16'h1234;
    @(negedge clk);
    in_valid = 1'b0;
    chk(main_code == 16'h1234, "R9", "first code", int'(main_code), 32'h1234);

    // R2 start pulse, unipolar, good targets, stream offered during the run
    run_cal(1'b0, 0, 1'b1, 1'b1);
    chk(main_code == 16'h1234, "R9", "code offered in run ignored", int'(main_code), 32'h1234);
    chk(int'(cal_code) == exp_entry(4), "R9", "word for held code", int'(cal_code), exp_entry(4));
    sweep(1'b0);

    // bipolar zero point
    run_cal(1'b1, 0, 1'b1, 1'b0);
    sweep(1'b1);

    // R7 search ending at all zeros
    bad_k = 5;
    bad_val = -1;
    run_cal(1'b0, 0, 1'b0, 1'b0);
    sweep(1'b0);

    // R7 search ending at all ones
    bad_val = 300;
    run_cal(1'b1, 0, 1'b0, 1'b0);
    sweep(1'b1);

    // R8 restart in the middle of a run, after a failed run
    bad_k = -1;
    run_cal(1'b0, 300, 1'b1, 1'b0);
    sweep(1'b0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule